// File: doc/BRIEF.md
# Page Write Buffer and Sequencer

This block sits behind the serial front end of a serial memory. It buffers the data of one page write command, and when chip select is released it decides whether to run a self-timed program cycle. When the front end decodes the page write opcode and its three address bytes, it pulses a command strobe with the start address. At that moment the block samples the write-enable state and the block-protection level from the protection logic. Each completed data byte is then stored in a 256-entry page buffer at an in-page offset. The offset starts at the low address byte and steps by one, wrapping inside the page. A per-offset valid mask records which offsets have actually been received.

The commit decision is made when chip select falls away. The transaction is committed only if it was permitted, carried at least one byte, and ended exactly on a byte boundary, with no partial byte shifted in. Anything else is dropped as a whole. A committed cycle raises busy for a parameterised number of system clocks. During the first 256 of those clocks it walks the buffer in ascending offset order and writes each received byte to the array port. Each byte is written as a full value, so no erase pass is needed. At the end it pulses a request that clears the write-enable latch. While busy, new commands and bytes are ignored.

Top module: `page_wr_seq`

## Requirements
- R1: Out of reset `busy_o`, `mem_we_o` and `wen_clr_o` are all 0.
- R2: Bytes are buffered at the in-page offset given by `addr_i[7:0]`, plus one per byte. They are written to `{addr_i[17:8], offset}` with the received value.
- R3: The offset wraps modulo 256. A later byte at an offset already filled replaces the earlier one, so only the last value is written.
- R4: The transaction commits only if at least one byte arrived and `partial_i` is 0 in the first cycle `sel_i` reads 0. Otherwise nothing is written and `busy_o` stays 0.
- R5: If `wen_i` is 0 when `cmd_pw_i` is sampled, the transaction is dropped.
- R6: `prot_lvl_i` is sampled with the command: 0 protects nothing, 1 protects `addr_i[17:16]==2'b11`, 2 protects `addr_i[17]==1`, and 3 protects the whole array. A protected target drops the transaction.
- R7: `busy_o` rises on the clock after the first cycle `sel_i` reads 0, and stays high for exactly `CYC_CLKS` cycles.
- R8: Array writes occur only while busy, at most one per cycle, in strictly ascending offset order. Exactly one write is made per received offset, and the page stays constant throughout.
- R9: `wen_clr_o` is a single-cycle pulse in the first cycle after `busy_o` falls, once per committed cycle and never otherwise.
- R10: `cmd_pw_i` and `byte_vld_i` are ignored while `busy_o` is 1. They neither start nor alter a cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Chip selected (active high, synchronised) |
| cmd_pw_i | input | 1 | Page write command decoded, address valid |
| addr_i | input | 18 | Start byte address |
| wen_i | input | 1 | Write-enable latch state |
| prot_lvl_i | input | 2 | Block-protection level |
| byte_vld_i | input | 1 | One data byte complete |
| byte_i | input | 8 | Data byte |
| partial_i | input | 1 | Some bits of an unfinished byte are shifted in |
| busy_o | output | 1 | Program cycle in progress |
| wen_clr_o | output | 1 | Pulse: clear the write-enable latch |
| mem_we_o | output | 1 | Array write strobe |
| mem_addr_o | output | 18 | Array write address |
| mem_wdata_o | output | 8 | Array write data |

## Verification
Single-byte writes show that the base offset and page are applied. A run that starts at offset 0xFE shows wrap order against plain increment. A 258-byte run separates overwrite-with-latest from first-wins or spill into the next page. Endings with a partial byte or with no bytes, a cleared write enable, and each protection level at an address just inside and just outside its range each separate a dropped transaction from a committed one. A second command issued during busy shows that the running cycle keeps its length and data.

// File: rtl/pwseq_pkg.sv
package pwseq_pkg;

  typedef enum logic [1:0] {
    PL_NONE = 2'd0,
    PL_QTR  = 2'd1,
    PL_HALF = 2'd2,
    PL_ALL  = 2'd3
  } prot_lvl_e;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_st_e;

  // top2: two most significant address bits of the target
  function automatic logic page_locked(input logic [1:0] lvl, input logic [1:0] top2);
    logic lk;
    case (prot_lvl_e'(lvl))
      PL_NONE: lk = 1'b0;
      PL_QTR:  lk = (top2 == 2'b11);
      PL_HALF: lk = top2[1];
      default: lk = 1'b1;
    endcase
    return lk;
  endfunction

endpackage

// File: rtl/pwseq_gate.sv
module pwseq_gate
  import pwseq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_i,
  input  logic       cmd_i,
  input  logic       wen_i,
  input  logic [1:0] lvl_i,
  input  logic [1:0] top_i,
  input  logic       byte_vld_i,
  input  logic       partial_i,
  input  logic       busy_i,
  output logic       load_o,
  output logic       wr_o,
  output logic       commit_o
);

  logic sel_q, arm_q, arm_d, has_q, has_d;
  logic desel;

  assign desel    = sel_q & ~sel_i;
  assign load_o   = cmd_i & ~busy_i;
  assign wr_o     = byte_vld_i & arm_q;
  assign commit_o = desel & arm_q & has_q & ~partial_i;

  always_comb begin
    arm_d = arm_q;
    has_d = has_q;
    if (load_o) begin
      arm_d = wen_i & ~page_locked(lvl_i, top_i);
      has_d = 1'b0;
    end else begin
      if (desel) arm_d = 1'b0;
      if (wr_o)  has_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q <= 1'b0;
      arm_q <= 1'b0;
      has_q <= 1'b0;
    end else begin
      sel_q <= sel_i;
      arm_q <= arm_d;
      has_q <= has_d;
    end
  end

endmodule

// File: rtl/pwseq_capture.sv
module pwseq_capture #(
  parameter int ADDR_W = 18,
  parameter int PAGE_W = 8,
  parameter int DATA_W = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load_i,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic                     wr_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic [PAGE_W-1:0]        rd_idx_i,
  output logic [DATA_W-1:0]        rd_data_o,
  output logic                     rd_vld_o,
  output logic [ADDR_W-PAGE_W-1:0] page_o
);

  localparam int ENTRIES = 1 << PAGE_W;
  localparam int PG_W    = ADDR_W - PAGE_W;

  logic [DATA_W-1:0] mem_q [ENTRIES];
  logic [ENTRIES-1:0] mask_q, mask_d;
  logic [PAGE_W-1:0]  ptr_q, ptr_d;
  logic [PG_W-1:0]    page_q, page_d;

  always_comb begin
    mask_d = mask_q;
    ptr_d  = ptr_q;
    page_d = page_q;
    if (load_i) begin
      mask_d = '0;
      ptr_d  = addr_i[PAGE_W-1:0];
      page_d = addr_i[ADDR_W-1:PAGE_W];
    end else if (wr_i) begin
      mask_d[ptr_q] = 1'b1;
      ptr_d         = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      ptr_q  <= '0;
      page_q <= '0;
    end else begin
      mask_q <= mask_d;
      ptr_q  <= ptr_d;
      page_q <= page_d;
    end
  end

  // data storage: enabled write, no reset
  always_ff @(posedge clk) begin
    if (wr_i && !load_i) mem_q[ptr_q] <= data_i;
  end

  assign rd_data_o = mem_q[rd_idx_i];
  assign rd_vld_o  = mask_q[rd_idx_i];
  assign page_o    = page_q;

endmodule

// File: rtl/pwseq_prog.sv
module pwseq_prog
  import pwseq_pkg::*;
#(
  parameter int PAGE_W   = 8,
  parameter int CYC_CLKS = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              commit_i,
  output logic              busy_o,
  output logic              walk_o,
  output logic [PAGE_W-1:0] idx_o,
  output logic              wen_clr_o
);

  localparam int TW = $clog2(CYC_CLKS + 1);
  localparam logic [TW-1:0] T_LAST = TW'(CYC_CLKS - 1);

  seq_st_e           st_q, st_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic [PAGE_W-1:0] idx_q, idx_d;
  logic              walk_q, walk_d;
  logic              clr_q, clr_d;

  always_comb begin
    st_d   = st_q;
    tmr_d  = tmr_q;
    idx_d  = idx_q;
    walk_d = walk_q;
    clr_d  = 1'b0;
    case (st_q)
      SQ_IDLE: begin
        if (commit_i) begin
          st_d   = SQ_RUN;
          tmr_d  = '0;
          idx_d  = '0;
          walk_d = 1'b1;
        end
      end
      default: begin
        tmr_d = tmr_q + 1'b1;
        if (walk_q) begin
          idx_d = idx_q + 1'b1;
          if (&idx_q) walk_d = 1'b0;
        end
        if (tmr_q == T_LAST) begin
          st_d   = SQ_IDLE;
          walk_d = 1'b0;
          clr_d  = 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= SQ_IDLE;
      tmr_q  <= '0;
      idx_q  <= '0;
      walk_q <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      tmr_q  <= tmr_d;
      idx_q  <= idx_d;
      walk_q <= walk_d;
      clr_q  <= clr_d;
    end
  end

  assign busy_o    = (st_q == SQ_RUN);
  assign walk_o    = walk_q & busy_o;
  assign idx_o     = idx_q;
  assign wen_clr_o = clr_q;

endmodule

// File: rtl/page_wr_seq.sv
module page_wr_seq #(
  parameter int ADDR_W   = 18,
  parameter int PAGE_W   = 8,
  parameter int DATA_W   = 8,
  parameter int CYC_CLKS = 300
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel_i,
  input  logic              cmd_pw_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wen_i,
  input  logic [1:0]        prot_lvl_i,
  input  logic              byte_vld_i,
  input  logic [DATA_W-1:0] byte_i,
  input  logic              partial_i,
  output logic              busy_o,
  output logic              wen_clr_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);

  localparam int PG_W = ADDR_W - PAGE_W;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              load, wr, commit, walk, rd_vld;
  logic [PAGE_W-1:0] idx;
  logic [DATA_W-1:0] rd_data;
  logic [PG_W-1:0]   page;

  pwseq_gate u_gate (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .sel_i     (sel_i),
    .cmd_i     (cmd_pw_i),
    .wen_i     (wen_i),
    .lvl_i     (prot_lvl_i),
    .top_i     (addr_i[ADDR_W-1 -: 2]),
    .byte_vld_i(byte_vld_i),
    .partial_i (partial_i),
    .busy_i    (busy_o),
    .load_o    (load),
    .wr_o      (wr),
    .commit_o  (commit)
  );

  pwseq_capture #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W)) u_cap (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .load_i   (load),
    .addr_i   (addr_i),
    .wr_i     (wr),
    .data_i   (byte_i),
    .rd_idx_i (idx),
    .rd_data_o(rd_data),
    .rd_vld_o (rd_vld),
    .page_o   (page)
  );

  pwseq_prog #(.PAGE_W(PAGE_W), .CYC_CLKS(CYC_CLKS)) u_prog (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .commit_i (commit),
    .busy_o   (busy_o),
    .walk_o   (walk),
    .idx_o    (idx),
    .wen_clr_o(wen_clr_o)
  );

  assign mem_we_o    = walk & rd_vld;
  assign mem_addr_o  = {page, idx};
  assign mem_wdata_o = rd_data;

endmodule

// File: rtl/page_wr_seq_chk.sv
module page_wr_seq_chk #(
  parameter int ADDR_W   = 18,
  parameter int PAGE_W   = 8,
  parameter int DATA_W   = 8,
  parameter int CYC_CLKS = 300
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sel_i,
  input logic              cmd_pw_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              wen_i,
  input logic [1:0]        prot_lvl_i,
  input logic              byte_vld_i,
  input logic [DATA_W-1:0] byte_i,
  input logic              partial_i,
  input logic              busy_o,
  input logic              wen_clr_o,
  input logic              mem_we_o,
  input logic [ADDR_W-1:0] mem_addr_o,
  input logic [DATA_W-1:0] mem_wdata_o
);

  int unsigned busy_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      busy_run <= 0;
    else if (busy_o) busy_run <= busy_run + 1;
    else             busy_run <= 0;
  end

  AST_WE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we_o |-> busy_o);  // R8

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> $stable(mem_addr_o[ADDR_W-1:PAGE_W]));  // R8

  AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> busy_run == CYC_CLKS);  // R7

  AST_CLR_ON_END: assert property (@(posedge clk) disable iff (!rst_n)
    wen_clr_o |-> $fell(busy_o));  // R9

  AST_END_GIVES_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> wen_clr_o);  // R9

  AST_START_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy_o) |-> !$past(sel_i) && !$past(partial_i));  // R4

endmodule

bind page_wr_seq page_wr_seq_chk #(
  .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .DATA_W(DATA_W), .CYC_CLKS(CYC_CLKS)
) u_chk (.*);

// File: tb/page_wr_seq_tb.sv
module page_wr_seq_tb;

  localparam int CYC = 300;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sel = 1'b0, cmd = 1'b0, wen = 1'b0, bv = 1'b0, part = 1'b0;
  logic [17:0] addr = '0;
  logic [1:0]  lvl = '0;
  logic [7:0]  bdat = '0;
  logic        busy, wclr, we;
  logic [17:0] maddr;
  logic [7:0]  mdat;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  page_wr_seq #(.CYC_CLKS(CYC)) u_dut (
    .clk(clk), .rst_n(rst_n), .sel_i(sel), .cmd_pw_i(cmd), .addr_i(addr),
    .wen_i(wen), .prot_lvl_i(lvl), .byte_vld_i(bv), .byte_i(bdat),
    .partial_i(part), .busy_o(busy), .wen_clr_o(wclr), .mem_we_o(we),
    .mem_addr_o(maddr), .mem_wdata_o(mdat)
  );

  bit         exp_v [256];
  logic [7:0] exp_d [256];
  bit         rec_v [256];
  logic [7:0] rec_d [256];
  bit         exp_go;
  logic [9:0] exp_page;
  int busy_cnt, clr_cnt, wr_cnt, ord_err, page_err, prev_idx;

  always @(negedge clk) begin
    if (busy) busy_cnt++;
    if (wclr) clr_cnt++;
    if (we) begin
      wr_cnt++;
      if (int'(maddr[7:0]) <= prev_idx) ord_err++;
      prev_idx = int'(maddr[7:0]);
      if (maddr[17:8] != exp_page) page_err++;
      rec_v[maddr[7:0]] = 1'b1;
      rec_d[maddr[7:0]] = mdat;
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: %s actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic bit locked(input logic [1:0] l, input logic [17:0] a);
    case (l)
      2'd0: return 1'b0;
      2'd1: return a[17:16] == 2'b11;
      2'd2: return a[17];
      default: return 1'b1;
    endcase
  endfunction

  task automatic clear_mon();
    busy_cnt = 0; clr_cnt = 0; wr_cnt = 0; ord_err = 0; page_err = 0; prev_idx = -1;
    for (int i = 0; i < 256; i++) begin rec_v[i] = 1'b0; rec_d[i] = '0; end
  endtask

  task automatic drive_tx(input logic [17:0] a, input int n, input logic [7:0] seed,
                          input logic w, input logic [1:0] l, input logic pt, input bit model);
    if (model) begin
      for (int i = 0; i < 256; i++) begin exp_v[i] = 1'b0; exp_d[i] = '0; end
      exp_page = a[17:8];
      exp_go = w && !locked(l, a) && (n > 0) && !pt;
    end
    @(negedge clk);
    sel = 1'b1; cmd = 1'b1; addr = a; wen = w; lvl = l;
    @(negedge clk);
    cmd = 1'b0;
    for (int i = 0; i < n; i++) begin
      bv = 1'b1; bdat = seed + 8'(i);
      if (model) begin
        exp_v[(int'(a[7:0]) + i) % 256] = 1'b1;
        exp_d[(int'(a[7:0]) + i) % 256] = seed + 8'(i);
      end
      @(negedge clk); bv = 1'b0;
      @(negedge clk);
    end
    part = pt; sel = 1'b0;
    @(negedge clk);
    part = 1'b0;
  endtask

  task automatic observe(input string req);
    int n_exp = 0, bad = 0;
    repeat (CYC + 30) @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      if (exp_v[i]) n_exp++;
      if (exp_go && (exp_v[i] != rec_v[i] || (exp_v[i] && exp_d[i] != rec_d[i]))) bad++;
    end
    if (exp_go) begin
      chk(busy_cnt == CYC, "R7", "busy cycles", busy_cnt, CYC);
      chk(wr_cnt == n_exp, "R8", "write count", wr_cnt, n_exp);
      chk(bad == 0, req, "offset/data mismatches", bad, 0);
      chk(ord_err == 0 && page_err == 0, "R8", "order+page errors", ord_err + page_err, 0);
      chk(clr_cnt == 1, "R9", "wen clear pulses", clr_cnt, 1);
    end else begin
      chk(busy_cnt == 0, req, "busy cycles on dropped tx", busy_cnt, 0);
      chk(wr_cnt == 0, req, "writes on dropped tx", wr_cnt, 0);
      chk(clr_cnt == 0, "R9", "wen clear on dropped tx", clr_cnt, 0);
    end
  endtask

  task automatic t_reset();
    chk(busy == 0, "R1", "busy after reset", busy, 0);
    chk(we == 0, "R1", "we after reset", we, 0);
    chk(wclr == 0, "R1", "wen_clr after reset", wclr, 0);
  endtask

  task automatic t_single();   // R2
    clear_mon(); drive_tx(18'h00510, 1, 8'hA5, 1, 0, 0, 1); observe("R2");
    clear_mon(); drive_tx(18'h2C7F0, 3, 8'h3C, 1, 0, 0, 1); observe("R2");
  endtask

  task automatic t_wrap();     // R3
    clear_mon(); drive_tx(18'h123FE, 4, 8'h70, 1, 0, 0, 1); observe("R3");
    clear_mon(); drive_tx(18'h00400, 258, 8'h10, 1, 0, 0, 1); observe("R3");
  endtask

  task automatic t_boundary(); // R4
    clear_mon(); drive_tx(18'h00800, 2, 8'h55, 1, 0, 1, 1); observe("R4");
    clear_mon(); drive_tx(18'h00900, 0, 8'h00, 1, 0, 0, 1); observe("R4");
  endtask

  task automatic t_nowen();    // R5
    clear_mon(); drive_tx(18'h00A00, 3, 8'h21, 0, 0, 0, 1); observe("R5");
  endtask

  task automatic t_prot();     // R6
    clear_mon(); drive_tx(18'h30100, 2, 8'h01, 1, 1, 0, 1); observe("R6");
    clear_mon(); drive_tx(18'h2FF00, 2, 8'h02, 1, 1, 0, 1); observe("R6");
    clear_mon(); drive_tx(18'h20000, 2, 8'h03, 1, 2, 0, 1); observe("R6");
    clear_mon(); drive_tx(18'h1FF80, 2, 8'h04, 1, 2, 0, 1); observe("R6");
    clear_mon(); drive_tx(18'h00000, 2, 8'h05, 1, 3, 0, 1); observe("R6");
  endtask

  task automatic t_busy_ign(); // R10
    clear_mon();
    drive_tx(18'h01220, 3, 8'hC0, 1, 0, 0, 1);
    drive_tx(18'h03300, 3, 8'h99, 1, 0, 0, 0);
    observe("R10");
  endtask

  initial begin
    clear_mon();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_single();
    t_wrap();
    t_boundary();
    t_nowen();
    t_prot();
    t_busy_ign();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: run hung actual 1 expected 0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule